// File: doc/BRIEF.md
# Pixel Nibble and Color Swapper

This block sits in a pixel data path just ahead of a color lookup stage. It accepts one pixel word per handshake, together with a pixel-format code and two ordering controls. It then produces a registered stream of pixel values, each marked by a valid strobe.

For 4-bit pixels, each incoming byte is split into two pixels. These leave on two consecutive cycles, in an order that one control bit selects. While the second pixel is still to leave, the input is held off through a ready signal. For the direct-color formats (16, 24 and 32 bits per pixel), the other control bit can exchange the red and blue fields. This exchange happens before any palette lookup downstream.

A source-select input marks the word as coming from the legacy display port. Such a word passes through untouched, whatever the controls say.

Top module: `pix_swapper`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Format code 0 (4 bits per pixel) with `nib_swap`=0: an accepted byte yields `in_data[7:4]` on the next cycle and `in_data[3:0]` on the cycle after. Each appears in `out_data[3:0]`, with `out_data[31:4]` equal to 0.
- R3: Format code 0 with `nib_swap`=1: the same two beats leave in the reverse order, with `in_data[3:0]` first and `in_data[7:4]` second.
- R4: In the cycle after a 4-bit byte is accepted, `in_ready` is 0 and no new input is taken, even if `in_valid` stays high. `in_ready` returns to 1 with the second beat, and a held input is taken at the next edge.
- R5: `nib_swap` has no effect for any format code other than 0.
- R6: Format code 2 (16 bits, red in bits 15:11, green in bits 10:5, blue in bits 4:0) with `rb_swap`=1: bits 15:11 and 4:0 exchange. Bits 10:5 and 31:16 are unchanged.
- R7: Format codes 3 (24 bits) and 4 (32 bits) with `rb_swap`=1: bytes 23:16 and 7:0 exchange. Bits 15:8 and 31:24 are unchanged.
- R8: `rb_swap` is ignored for format codes 0, 1 (8 bits) and 5 to 7. In these modes a word of code 1 or 5 to 7 leaves unchanged, and the 4-bit nibbles are unaltered.
- R9: With `legacy_sel`=1, any accepted word leaves unchanged as a single beat on the next cycle, whatever the format and both swap controls.
- R10: Every accepted word of a non-split mode gives exactly one beat on the next cycle. `out_valid` is 0 in any cycle that follows neither an acceptance nor a pending second beat.
- R11: The order of the two 4-bit beats is fixed when the byte is accepted. A change of `nib_swap` while the second beat is pending does not alter that beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 32 | Pixel word; only bits 7:0 are used in 4-bit mode |
| fmt | input | 3 | Format code: 0=4, 1=8, 2=16, 3=24, 4=32 bits per pixel; 5 to 7 pass unchanged |
| nib_swap | input | 1 | Emit the low nibble first in 4-bit mode |
| rb_swap | input | 1 | Exchange red and blue in direct-color modes |
| legacy_sel | input | 1 | Legacy port source: bypass all swapping |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 32 | Output pixel value |

## Verification
In the same cycle, the pending second nibble of one byte can leave while a new byte is already on the input. The bench provokes this by keeping `in_valid` high across a 4-bit transfer, and by flipping `nib_swap` during the pending cycle. It judges the result by `in_ready` being 0 in that cycle, by the second beat following the order latched at acceptance, and by the next byte appearing only one cycle later in the newly selected order.

// File: rtl/pix_swap_pkg.sv
package pix_swap_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int FMT_W  = 3;
  localparam int R5_W   = 5;
  localparam int G6_W   = 6;

  typedef enum logic [FMT_W-1:0] {
    FMT_P4  = 3'd0,
    FMT_P8  = 3'd1,
    FMT_P16 = 3'd2,
    FMT_P24 = 3'd3,
    FMT_P32 = 3'd4
  } pix_fmt_e;

  function automatic logic fmt_is_direct(input logic [FMT_W-1:0] f);
    return (f == FMT_P16) || (f == FMT_P24) || (f == FMT_P32);
  endfunction

  function automatic logic [WORD_W-1:0] swap_565(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[R5_W-1:0]                   = w[R5_W+G6_W+R5_W-1:R5_W+G6_W];
    r[R5_W+G6_W+R5_W-1:R5_W+G6_W] = w[R5_W-1:0];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] swap_888(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    r[BYTE_W-1:0]          = w[3*BYTE_W-1:2*BYTE_W];
    r[3*BYTE_W-1:2*BYTE_W] = w[BYTE_W-1:0];
    return r;
  endfunction

  function automatic logic [NIB_W-1:0] pick_nib(input logic [BYTE_W-1:0] b,
                                               input logic hi);
    return hi ? b[BYTE_W-1:NIB_W] : b[NIB_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] zext_nib(input logic [NIB_W-1:0] n);
    return {{(WORD_W-NIB_W){1'b0}}, n};
  endfunction
endpackage

// File: rtl/pix_nib_split.sv
module pix_nib_split
  import pix_swap_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              low_first,
  output logic [NIB_W-1:0]  first_nib,
  output logic [NIB_W-1:0]  second_nib
);
  always_comb begin
    first_nib  = pick_nib(byte_in, !low_first);
    second_nib = pick_nib(byte_in,  low_first);
  end
endmodule

// File: rtl/pix_rb_xchg.sv
module pix_rb_xchg
  import pix_swap_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  logic [FMT_W-1:0]  fmt,
  input  logic              enable,
  output logic [WORD_W-1:0] word_out,
  output logic              exchanged
);
  always_comb begin
    word_out  = word_in;
    exchanged = 1'b0;
    if (enable && fmt_is_direct(fmt)) begin
      exchanged = 1'b1;
      if (fmt == FMT_P16) word_out = swap_565(word_in);
      else                word_out = swap_888(word_in);
    end
  end
endmodule

// File: rtl/pix_beat_seq.sv
module pix_beat_seq
  import pix_swap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              split,
  input  logic [NIB_W-1:0]  first_nib,
  input  logic [NIB_W-1:0]  second_nib,
  input  logic [WORD_W-1:0] direct_word,
  output logic              pending,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  logic [NIB_W-1:0] held_nib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      held_nib  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      if (split) begin
        out_data <= zext_nib(first_nib);
        held_nib <= second_nib;
        pending  <= 1'b1;
      end else begin
        out_data <= direct_word;
      end
    end else if (pending) begin
      out_valid <= 1'b1;
      out_data  <= zext_nib(held_nib);
      pending   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_swapper.sv
module pix_swapper
  import pix_swap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  input  logic [2:0]        fmt,
  input  logic              nib_swap,
  input  logic              rb_swap,
  input  logic              legacy_sel,
  output logic              out_valid,
  output logic [31:0]       out_data
);
  logic              accept;
  logic              split_go;
  logic              pending;
  logic              rb_active;
  logic [NIB_W-1:0]  first_nib;
  logic [NIB_W-1:0]  second_nib;
  logic [WORD_W-1:0] direct_word;

  assign in_ready  = !pending;
  assign accept    = in_valid && in_ready;
  assign split_go  = accept && (fmt == FMT_P4) && !legacy_sel;

  pix_nib_split u_split (
    .byte_in    (in_data[BYTE_W-1:0]),
    .low_first  (nib_swap),
    .first_nib  (first_nib),
    .second_nib (second_nib)
  );

  pix_rb_xchg u_xchg (
    .word_in   (in_data),
    .fmt       (fmt),
    .enable    (rb_swap && !legacy_sel),
    .word_out  (direct_word),
    .exchanged (rb_active)
  );

  pix_beat_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .split       (split_go),
    .first_nib   (first_nib),
    .second_nib  (second_nib),
    .direct_word (direct_word),
    .pending     (pending),
    .out_valid   (out_valid),
    .out_data    (out_data)
  );
endmodule

// File: rtl/pix_swapper_chk.sv
module pix_swapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_data,
  input logic [2:0]  fmt,
  input logic        nib_swap,
  input logic        rb_swap,
  input logic        legacy_sel,
  input logic        out_valid,
  input logic [31:0] out_data,
  input logic        accept,
  input logic        split_go,
  input logic        pending,
  input logic        rb_active
);
  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (!out_valid && in_ready)); // R1

  AST_NIB_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (split_go && !nib_swap) |=> (out_valid && out_data == {28'd0, $past(in_data[7:4])})); // R2

  AST_NIB_LO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (split_go && nib_swap) |=> (out_valid && out_data == {28'd0, $past(in_data[3:0])})); // R3

  AST_STALL_AFTER_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    split_go |=> !in_ready); // R4

  AST_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> (out_valid && in_ready && out_data[31:4] == 28'd0)); // R4

  AST_NO_RB_OUTSIDE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    rb_active |-> (fmt == 3'd2 || fmt == 3'd3 || fmt == 3'd4)); // R8

  AST_RB16_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fmt == 3'd2 && rb_swap && !legacy_sel) |=>
      (out_data == {$past(in_data[31:16]), $past(in_data[4:0]),
                    $past(in_data[10:5]), $past(in_data[15:11])})); // R6

  AST_LEGACY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && legacy_sel) |=> (out_valid && out_data == $past(in_data) && in_ready)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !pending) |=> !out_valid); // R10

  AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fmt != 3'd0 && !rb_swap) |=> (out_data == $past(in_data))); // R5
endmodule

bind pix_swapper pix_swapper_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .fmt        (fmt),
  .nib_swap   (nib_swap),
  .rb_swap    (rb_swap),
  .legacy_sel (legacy_sel),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .accept     (accept),
  .split_go   (split_go),
  .pending    (pending),
  .rb_active  (rb_active)
);

// File: tb/pix_swapper_tb.sv
module pix_swapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [2:0]  fmt = '0;
  logic        nib_swap = 1'b0;
  logic        rb_swap = 1'b0;
  logic        legacy_sel = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pix_swapper u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .fmt(fmt), .nib_swap(nib_swap), .rb_swap(rb_swap),
    .legacy_sel(legacy_sel), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] d, input int f,
                                        input bit rb, input bit leg);
    if (leg || !rb) return d;
    if (f == 2) return (d & 32'hFFFF_07E0) | ((d >> 11) & 32'h1F) | ((d & 32'h1F) << 11);
    if (f == 3 || f == 4) return (d & 32'hFF00_FF00) | ((d >> 16) & 32'hFF) | ((d & 32'hFF) << 16);
    return d;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_direct(input logic [31:0] d, input int f, input bit nb,
                          input bit rb, input bit leg, input string req);
    logic [31:0] e;
    e = model(d, f, rb, leg);
    @(negedge clk);
    in_data = d; fmt = 3'(f); nib_swap = nb; rb_swap = rb; legacy_sel = leg;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == e, req, out_data, e);
    @(negedge clk);
    chk(!out_valid && in_ready, "R10 single beat then idle", {30'd0, out_valid, in_ready}, 32'd1);
  endtask

  task automatic t_nibble(input logic [7:0] b, input bit sw, input bit rb, input string req);
    logic [3:0] a1, a2;
    a1 = sw ? b[3:0] : b[7:4];
    a2 = sw ? b[7:4] : b[3:0];
    @(negedge clk);
    in_data = {24'hA5C3E1, b}; fmt = 3'd0; nib_swap = sw; rb_swap = rb; legacy_sel = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == {28'd0, a1}, {req, " first beat"}, out_data, {28'd0, a1});
    chk(!in_ready, "R4 ready low while second pending", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    chk(out_valid && out_data == {28'd0, a2}, {req, " second beat"}, out_data, {28'd0, a2});
    chk(in_ready, "R4 ready back with second beat", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    chk(!out_valid, "R10 idle after pair", {31'd0, out_valid}, 32'd0);
  endtask

  // Input held while the second beat is pending; nib_swap flipped mid-pair.
  task automatic t_stall_overlap();
    @(negedge clk);
    in_data = 32'h0000_003C; fmt = 3'd0; nib_swap = 1'b0; rb_swap = 1'b0; legacy_sel = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    chk(out_data == 32'h3, "R2 overlap first A", out_data, 32'h3);
    chk(!in_ready, "R4 stalled with valid held", {31'd0, in_ready}, 32'd0);
    in_data = 32'h0000_009E; nib_swap = 1'b1;
    @(negedge clk);
    chk(out_valid && out_data == 32'hC, "R11 second A keeps latched order", out_data, 32'hC);
    chk(in_ready, "R4 ready after pending beat", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == 32'hE, "R3 held byte B first, new order", out_data, 32'hE);
    @(negedge clk);
    chk(out_valid && out_data == 32'h9, "R3 byte B second beat", out_data, 32'h9);
    @(negedge clk);
    chk(!out_valid, "R10 idle after overlap", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    fmt = 3'd3; rb_swap = 1'b1; nib_swap = 1'b0; legacy_sel = 1'b0;
    in_data = 32'h1122_3344; in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid && out_data == 32'h1144_3322, "R10 b2b word 1", out_data, 32'h1144_3322);
    chk(in_ready, "R10 ready stays high direct", {31'd0, in_ready}, 32'd1);
    in_data = 32'hDEAD_BEEF;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == 32'hDEEF_BEAD, "R10 b2b word 2", out_data, 32'hDEEF_BEAD);
    @(negedge clk);
    chk(!out_valid, "R10 idle after b2b", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_legacy_nibble();
    @(negedge clk);
    in_data = 32'h1234_56AB; fmt = 3'd0; nib_swap = 1'b1; rb_swap = 1'b1; legacy_sel = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_data == 32'h1234_56AB, "R9 legacy 4-bit whole word", out_data, 32'h1234_56AB);
    chk(in_ready, "R9 legacy no stall", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    chk(!out_valid, "R9 legacy single beat", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_nibble(8'h5A, 1'b0, 1'b0, "R2 high nibble first");
    t_nibble(8'h5A, 1'b1, 1'b0, "R3 low nibble first");
    t_nibble(8'hF0, 1'b0, 1'b1, "R8 rb ignored in 4-bit");
    t_stall_overlap();
    t_direct(32'h89AB_CDEF, 1, 1'b1, 1'b0, 1'b0, "R5 nib ignored 8-bit");
    t_direct(32'h1357_F00F, 2, 1'b1, 1'b0, 1'b0, "R5 nib ignored 16-bit");
    t_direct(32'hCAFE_F81F, 2, 1'b0, 1'b1, 1'b0, "R6 565 swap");
    t_direct(32'h0000_A5C3, 2, 1'b1, 1'b1, 1'b0, "R6 565 swap nib set");
    t_direct(32'h77AA_5533, 3, 1'b0, 1'b1, 1'b0, "R7 24-bit swap");
    t_direct(32'h9911_2233, 4, 1'b0, 1'b1, 1'b0, "R7 32-bit swap top byte kept");
    t_direct(32'h0102_0304, 1, 1'b0, 1'b1, 1'b0, "R8 rb ignored 8-bit");
    t_direct(32'h0506_0708, 5, 1'b0, 1'b1, 1'b0, "R8 rb ignored code 5");
    t_direct(32'hCAFE_F81F, 2, 1'b1, 1'b1, 1'b1, "R9 legacy 16-bit");
    t_direct(32'h77AA_5533, 4, 1'b0, 1'b1, 1'b1, "R9 legacy 32-bit");
    t_back_to_back();
    t_legacy_nibble();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule